// File: doc/BRIEF.md
# Keyboard-Controller-Style Message Transfer Engine

This block is the management-controller side of an IPMI KCS channel. It sits behind a register bank that reports each byte the host writes, tagged as either a control code or a data byte, and that exposes an output data register and a two-bit state field the host polls. The engine runs the message protocol on those signals. It collects the request bytes into a buffer and answers the request with a small built-in responder. It then hands the response to the host one byte per read code and recovers from aborts and protocol errors.

Each host byte arrives as a one-cycle `in_valid` pulse. One clock later the engine answers with strobes on the output data register (`out_we`/`out_byte`) and on the state field (`st_we`/`st_val`). The responder handles two fixed commands of the application network function and rejects every other request with an invalid-command completion code.

Top module: `kcs_xfer_engine`

## Requirements
- R1: After a synchronous active-low reset, neither `out_we` nor `st_we` pulses until a host byte arrives.
- R2: Every control code (in_cmd=1) is answered on the next cycle by a state-field write and a zero output byte. The state-field encoding is 0 idle, 1 read, 2 write, 3 error. Recognised codes are 0x61 (begin write), 0x62 (last write), 0x60 (status/abort) and 0x68 (read). For 0x61, 0x62 and 0x60 the state written is write (2).
- R3: After 0x61, each data byte is stored in the request buffer and answered with state write (2) and a zero output byte.
- R4: After 0x62, the next data byte is stored as the final request byte and answered with state read (1) and no output write. One cycle later the first response byte is written to the output.
- R5: Response bytes 0 and 1 echo request bytes 0 and 1, where a missing byte 1 reads as zero. Byte 2 is the completion code. If request byte 0 bits [7:2] equal 0x06 and byte 1 is 0x01, the completion code is 0x00 and 15 identity bytes follow (23 00 12 03 02 BF 57 01 00 7B 00 00 00 00 00), 18 bytes in all. If byte 1 is 0x04, the completion code is 0x00 followed by 56 00, 5 bytes in all. Any other request gets completion code 0xC1 and 3 bytes.
- R6: In the read phase, each 0x68 data byte outputs the next response byte. The 0x68 after the last response byte writes state idle (0) and a zero output, and the engine returns to idle.
- R7: In the read phase, a data byte other than 0x68 writes state error (3) and a zero output. The response position is left unchanged.
- R8: Control code 0x60 enters a two-step abort. The next data byte is answered with state read (1) and output 0x01. The data byte after that is answered with state idle (0) and output 0x00, and the engine returns to idle.
- R9: An unrecognised control code forces an abort: state error (3) and a zero output. A following 0x62 is also aborted in the same way.
- R10: A data byte that would exceed REQ_DEPTH stored request bytes, including the final byte, forces an abort with state error (3) and a zero output. A following 0x62 is also aborted.
- R11: A data byte in the idle or error phase forces an abort with state error (3) and a zero output, and a following 0x62 is aborted too. A new 0x61 restores normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle pulse: host wrote a byte |
| in_cmd | input | 1 | 1 = byte is a control code, 0 = data byte |
| in_byte | input | 8 | Byte written by the host |
| out_we | output | 1 | Write strobe for the output data register |
| out_byte | output | 8 | Byte to place in the output data register |
| st_we | output | 1 | Write strobe for the state field |
| st_val | output | 2 | State-field value (0 idle, 1 read, 2 write, 3 error) |

## Verification
The message path is swept with request headers built from four network-function bytes: two that decode to the application function through different low bits, and two that do not. Each header is paired with every command value from 0 to 7. This separates the two recognised commands from their near neighbours and from a correct command under the wrong function. A single-byte request, a request that exactly fills the buffer and one that overflows it by one byte probe the buffer boundary and the zero-fill of a missing command byte. Wrong read codes in mid-response, unknown control codes, stray data bytes and the status/abort sequence each show whether the engine keeps its position or aborts, and whether it recovers.

// File: rtl/kcs_xfer_pkg.sv
// Shared definitions for the KCS message transfer engine: phases,
// state-field encoding, control codes, error codes and the identity table.
package kcs_xfer_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_WSTART,
        PH_WDATA,
        PH_WEND,
        PH_RWAIT,
        PH_READ,
        PH_ABORT1,
        PH_ABORT2,
        PH_ERROR
    } phase_e;

    // Encoding of the host-visible state field
    localparam logic [1:0] HS_IDLE  = 2'd0;
    localparam logic [1:0] HS_READ  = 2'd1;
    localparam logic [1:0] HS_WRITE = 2'd2;
    localparam logic [1:0] HS_ERROR = 2'd3;

    // Host control codes
    localparam logic [7:0] CODE_ABORT  = 8'h60;
    localparam logic [7:0] CODE_WSTART = 8'h61;
    localparam logic [7:0] CODE_WEND   = 8'h62;
    localparam logic [7:0] CODE_READ   = 8'h68;

    // Error codes kept by the engine
    localparam logic [7:0] ERR_NONE    = 8'h00;
    localparam logic [7:0] ERR_ABORTED = 8'h01;
    localparam logic [7:0] ERR_ILLEGAL = 8'h02;
    localparam logic [7:0] ERR_LENGTH  = 8'h06;

    // Responder constants
    localparam logic [7:0] CC_OK      = 8'h00;
    localparam logic [7:0] CC_INVALID = 8'hC1;
    localparam int         RSP_MAX    = 18;
    localparam int         RSP_W      = $clog2(RSP_MAX + 1);

    // Identity payload byte k (0..14) returned by the identity command
    function automatic logic [7:0] ident_byte(input logic [3:0] k);
        case (k)
            4'd0:    return 8'h23;
            4'd2:    return 8'h12;
            4'd3:    return 8'h03;
            4'd4:    return 8'h02;
            4'd5:    return 8'hBF;
            4'd6:    return 8'h57;
            4'd7:    return 8'h01;
            4'd9:    return 8'h7B;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/kcs_req_buf.sv
// Request buffer: stores host request bytes in arrival order.
// Assumes clr and wr never pulse in the same cycle. Writes past
// REQ_DEPTH are dropped; the controller treats `full` as overflow.
// Exposes the first two stored bytes, reading as zero when absent.
module kcs_req_buf #(
    parameter int REQ_DEPTH = 32,
    parameter int CNT_W     = $clog2(REQ_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr,
    input  logic [7:0] wr_byte,
    output logic       full,
    output logic [7:0] first,
    output logic [7:0] second
);

    logic [CNT_W-1:0] cnt_q;

    assign full = (cnt_q == CNT_W'(REQ_DEPTH));

    // Byte count: cleared on a new message, advanced on each accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (wr && !full)
            cnt_q <= cnt_q + 1'b1;
    end

    // One storage slot per buffer entry
    for (genvar k = 0; k < REQ_DEPTH; k++) begin : g_slot
        logic [7:0] q;
        // Capture the incoming byte when this slot is next in line
        always_ff @(posedge clk) begin
            if (wr && !full && cnt_q == CNT_W'(k))
                q <= wr_byte;
        end
    end

    assign first  = (cnt_q >= CNT_W'(1)) ? g_slot[0].q : 8'h00;
    assign second = (cnt_q >= CNT_W'(2)) ? g_slot[1].q : 8'h00;

    // R10: the stored count never exceeds the buffer depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(REQ_DEPTH));

    // R3: an accepted byte advances the count by exactly one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !full && !clr) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/kcs_responder.sv
// Built-in request responder. Purely combinational: produces response
// byte `idx` and the total response length from the first two request
// bytes. Assumes the request bytes stay stable while a response streams.
module kcs_responder
    import kcs_xfer_pkg::*;
(
    input  logic [7:0]       req0,
    input  logic [7:0]       req1,
    input  logic [RSP_W-1:0] idx,
    output logic [7:0]       rsp_byte,
    output logic [RSP_W-1:0] rsp_len
);

    logic             app_fn;
    logic             is_ident;
    logic             is_selftest;
    logic [RSP_W-1:0] off;

    assign app_fn      = (req0[7:2] == 6'h06);
    assign is_ident    = app_fn && (req1 == 8'h01);
    assign is_selftest = app_fn && (req1 == 8'h04);
    assign off         = idx - RSP_W'(3);

    // Select the response length for the decoded command
    always_comb begin
        if (is_ident)
            rsp_len = RSP_W'(RSP_MAX);
        else if (is_selftest)
            rsp_len = RSP_W'(5);
        else
            rsp_len = RSP_W'(3);
    end

    // Produce the response byte at position idx
    always_comb begin
        if (idx == RSP_W'(0))
            rsp_byte = req0;
        else if (idx == RSP_W'(1))
            rsp_byte = req1;
        else if (idx == RSP_W'(2))
            rsp_byte = (is_ident || is_selftest) ? CC_OK : CC_INVALID;
        else if (is_ident)
            rsp_byte = ident_byte(off[3:0]);
        else if (is_selftest && idx == RSP_W'(3))
            rsp_byte = 8'h56;
        else
            rsp_byte = 8'h00;
    end

endmodule

// File: rtl/kcs_phase_ctl.sv
// Phase controller: decodes each host byte against the current phase,
// drives the buffer and the registered output/state strobes, and walks
// the response. Assumes no host byte arrives in the single cycle spent
// in the read-wait phase (such a byte is treated as a protocol error).
module kcs_phase_ctl
    import kcs_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_cmd,
    input  logic [7:0]       in_byte,
    input  logic             buf_full,
    input  logic [7:0]       rsp_byte,
    input  logic [RSP_W-1:0] rsp_len,
    output logic             buf_clr,
    output logic             buf_wr,
    output logic [RSP_W-1:0] rsp_idx,
    output logic             out_we,
    output logic [7:0]       out_byte,
    output logic             st_we,
    output logic [1:0]       st_val
);

    phase_e           phase_q, phase_d;
    logic [7:0]       err_q, err_d;
    logic [RSP_W-1:0] idx_q, idx_d;
    logic             owe_d, swe_d;
    logic [7:0]       ob_d;
    logic [1:0]       sv_d;
    logic             abort;

    assign rsp_idx = idx_q;

    // Next-state decode of one host byte or of the read-wait step
    always_comb begin
        phase_d = phase_q;
        err_d   = err_q;
        idx_d   = idx_q;
        owe_d   = 1'b0;
        ob_d    = out_byte;
        swe_d   = 1'b0;
        sv_d    = st_val;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        abort   = 1'b0;
        if (in_valid && in_cmd) begin
            swe_d = 1'b1;
            sv_d  = HS_WRITE;
            owe_d = 1'b1;
            ob_d  = 8'h00;
            case (in_byte)
                CODE_WSTART: begin
                    buf_clr = 1'b1;
                    err_d   = ERR_NONE;
                    idx_d   = '0;
                    phase_d = PH_WSTART;
                end
                CODE_WEND: begin
                    if (err_q != ERR_NONE)
                        abort = 1'b1;
                    else
                        phase_d = PH_WEND;
                end
                CODE_ABORT: begin
                    err_d   = ERR_ABORTED;
                    phase_d = PH_ABORT1;
                end
                default: begin
                    err_d = ERR_ILLEGAL;
                    abort = 1'b1;
                end
            endcase
        end else if (in_valid) begin
            case (phase_q)
                PH_WSTART, PH_WDATA: begin
                    if (buf_full) begin
                        err_d = ERR_LENGTH;
                        abort = 1'b1;
                    end else begin
                        swe_d   = 1'b1;
                        sv_d    = HS_WRITE;
                        owe_d   = 1'b1;
                        ob_d    = 8'h00;
                        buf_wr  = 1'b1;
                        phase_d = PH_WDATA;
                    end
                end
                PH_WEND: begin
                    if (buf_full) begin
                        err_d = ERR_LENGTH;
                        abort = 1'b1;
                    end else begin
                        swe_d   = 1'b1;
                        sv_d    = HS_READ;
                        buf_wr  = 1'b1;
                        phase_d = PH_RWAIT;
                    end
                end
                PH_READ: begin
                    swe_d = 1'b1;
                    owe_d = 1'b1;
                    if (in_byte != CODE_READ) begin
                        sv_d = HS_ERROR;
                        ob_d = 8'h00;
                    end else if (idx_q == rsp_len) begin
                        sv_d    = HS_IDLE;
                        ob_d    = 8'h00;
                        phase_d = PH_IDLE;
                    end else begin
                        swe_d = 1'b0;
                        ob_d  = rsp_byte;
                        idx_d = idx_q + 1'b1;
                    end
                end
                PH_ABORT1: begin
                    swe_d   = 1'b1;
                    sv_d    = HS_READ;
                    owe_d   = 1'b1;
                    ob_d    = err_q;
                    phase_d = PH_ABORT2;
                end
                PH_ABORT2: begin
                    swe_d   = 1'b1;
                    sv_d    = HS_IDLE;
                    owe_d   = 1'b1;
                    ob_d    = 8'h00;
                    phase_d = PH_IDLE;
                end
                default: begin
                    if (err_q == ERR_NONE)
                        err_d = ERR_ILLEGAL;
                    abort = 1'b1;
                end
            endcase
        end else if (phase_q == PH_RWAIT) begin
            owe_d   = 1'b1;
            ob_d    = rsp_byte;
            idx_d   = idx_q + 1'b1;
            phase_d = PH_READ;
        end
        if (abort) begin
            swe_d   = 1'b1;
            sv_d    = HS_ERROR;
            owe_d   = 1'b1;
            ob_d    = 8'h00;
            buf_clr = 1'b1;
            phase_d = PH_ERROR;
        end
    end

    // Phase, error code, response position and output strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            err_q    <= ERR_NONE;
            idx_q    <= '0;
            out_we   <= 1'b0;
            out_byte <= 8'h00;
            st_we    <= 1'b0;
            st_val   <= HS_IDLE;
        end else begin
            phase_q  <= phase_d;
            err_q    <= err_d;
            idx_q    <= idx_d;
            out_we   <= owe_d;
            out_byte <= ob_d;
            st_we    <= swe_d;
            st_val   <= sv_d;
        end
    end

    // R2: a control code is always answered with a write or error state
    p_cmd_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cmd) |=> st_we && (st_val == HS_WRITE || st_val == HS_ERROR));

    // R4: the read-wait step emits the first response byte and moves on
    p_first_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RWAIT && !in_valid) |=> out_we && phase_q == PH_READ);

    // R6: the response position never passes the response length
    p_read_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_READ) |-> idx_q <= rsp_len);

    // R8: the first abort step reports the abort error code
    p_abort_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ABORT1 && in_valid && !in_cmd) |=> out_we && out_byte == ERR_ABORTED);

    // R9: entering the error phase is reported as error state with zero output
    p_error_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ERROR && $past(phase_q) != PH_ERROR)
            |-> st_we && st_val == HS_ERROR && out_we && out_byte == 8'h00);

endmodule

// File: rtl/kcs_xfer_engine.sv
// Top of the KCS message transfer engine: request buffer, built-in
// responder and phase controller. Assumes one host byte per in_valid
// pulse and at least one idle cycle after the final request byte.
module kcs_xfer_engine
    import kcs_xfer_pkg::*;
#(
    parameter int REQ_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_cmd,
    input  logic [7:0] in_byte,
    output logic       out_we,
    output logic [7:0] out_byte,
    output logic       st_we,
    output logic [1:0] st_val
);

    localparam int CNT_W = $clog2(REQ_DEPTH + 1);

    logic             buf_clr, buf_wr, buf_full;
    logic [7:0]       req0, req1, rsp_byte;
    logic [RSP_W-1:0] rsp_idx, rsp_len;

    kcs_req_buf #(
        .REQ_DEPTH (REQ_DEPTH),
        .CNT_W     (CNT_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr      (buf_wr),
        .wr_byte (in_byte),
        .full    (buf_full),
        .first   (req0),
        .second  (req1)
    );

    kcs_responder u_rsp (
        .req0     (req0),
        .req1     (req1),
        .idx      (rsp_idx),
        .rsp_byte (rsp_byte),
        .rsp_len  (rsp_len)
    );

    kcs_phase_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_cmd   (in_cmd),
        .in_byte  (in_byte),
        .buf_full (buf_full),
        .rsp_byte (rsp_byte),
        .rsp_len  (rsp_len),
        .buf_clr  (buf_clr),
        .buf_wr   (buf_wr),
        .rsp_idx  (rsp_idx),
        .out_we   (out_we),
        .out_byte (out_byte),
        .st_we    (st_we),
        .st_val   (st_val)
    );

endmodule

// File: tb/test_kcs_xfer_engine.sv
// Self-checking bench: sweeps request headers and commands through a
// 4-byte-buffer engine and checks each host-visible strobe.
module test_kcs_xfer_engine;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_cmd = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_we;
    logic [7:0] out_byte;
    logic       st_we;
    logic [1:0] st_val;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    kcs_xfer_engine #(.REQ_DEPTH(DEPTH)) i_kcs_xfer_engine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmd(in_cmd),
        .in_byte(in_byte), .out_we(out_we), .out_byte(out_byte),
        .st_we(st_we), .st_val(st_val)
    );

    // Compare the strobes; byte and state value only matter when strobed
    task automatic expect_io(input string r, input bit ewe, input logic [7:0] eb,
                             input bit swe, input logic [1:0] sv);
        logic [11:0] act, exp;
        act = {out_we, out_we ? out_byte : 8'h00, st_we, st_we ? st_val : 2'b00};
        exp = {ewe, ewe ? eb : 8'h00, swe, swe ? sv : 2'b00};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", r, act, exp);
        end
    endtask

    // Present one host byte for one cycle; outputs are valid on return
    task automatic put(input bit cmd, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_cmd   = cmd;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [7:0] ident(input int k);
        case (k)
            0: return 8'h23; 2: return 8'h12; 3: return 8'h03; 4: return 8'h02;
            5: return 8'hBF; 6: return 8'h57; 7: return 8'h01; 9: return 8'h7B;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int model_len(input logic [7:0] a, input logic [7:0] b);
        if ((a >> 2) == 8'd6 && b == 8'h01) return 18;
        if ((a >> 2) == 8'd6 && b == 8'h04) return 5;
        return 3;
    endfunction

    function automatic logic [7:0] model_byte(input logic [7:0] a, input logic [7:0] b,
                                              input int i);
        int n;
        n = model_len(a, b);
        if (i == 0) return a;
        if (i == 1) return b;
        if (i == 2) return (n == 3) ? 8'hC1 : 8'h00;
        if (n == 18) return ident(i - 3);
        if (n == 5 && i == 3) return 8'h56;
        return 8'h00;
    endfunction

    // Write phase of a request; nbytes of {a,b,fill...}
    task automatic write_req(input string r, input logic [7:0] a, input logic [7:0] b,
                             input int nbytes);
        put(1'b1, 8'h61);
        expect_io({r, " R2 begin"}, 1'b1, 8'h00, 1'b1, 2'd2);
        for (int i = 0; i < nbytes - 1; i++) begin
            put(1'b0, (i == 0) ? a : (i == 1) ? b : 8'hEE);
            expect_io({r, " R3 data"}, 1'b1, 8'h00, 1'b1, 2'd2);
        end
        put(1'b1, 8'h62);
        expect_io({r, " R2 last"}, 1'b1, 8'h00, 1'b1, 2'd2);
        put(1'b0, (nbytes == 1) ? a : (nbytes == 2) ? b : 8'hEE);
    endtask

    // Full request and response, checked byte by byte
    task automatic run_req(input string r, input logic [7:0] a, input logic [7:0] b,
                           input int nbytes);
        logic [7:0] eb;
        int n;
        eb = (nbytes >= 2) ? b : 8'h00;
        n  = model_len(a, eb);
        write_req(r, a, b, nbytes);
        expect_io({r, " R4 final"}, 1'b0, 8'h00, 1'b1, 2'd1);
        @(negedge clk);
        expect_io({r, " R4 first"}, 1'b1, model_byte(a, eb, 0), 1'b0, 2'd0);
        for (int i = 1; i < n; i++) begin
            put(1'b0, 8'h68);
            expect_io({r, " R5 byte"}, 1'b1, model_byte(a, eb, i), 1'b0, 2'd0);
        end
        put(1'b0, 8'h68);
        expect_io({r, " R6 done"}, 1'b1, 8'h00, 1'b1, 2'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] hdr [4];
        hdr[0] = 8'h18; hdr[1] = 8'h1B; hdr[2] = 8'h1C; hdr[3] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            expect_io("R1 reset", 1'b0, 8'h00, 1'b0, 2'd0);
        end

        // R5/R6 sweep: four headers by eight commands
        for (int h = 0; h < 4; h++)
            for (int c = 0; c < 8; c++)
                run_req("R5 sweep", hdr[h], 8'(c), 2);

        // R5: single-byte request, missing command reads as zero
        run_req("R5 single", 8'h18, 8'h55, 1);
        // R10 boundary: exactly DEPTH bytes accepted
        run_req("R10 exact", 8'h18, 8'h04, DEPTH);

        // R7: wrong read code keeps position
        write_req("R7", 8'h18, 8'h04, 2);
        expect_io("R7 final", 1'b0, 8'h00, 1'b1, 2'd1);
        @(negedge clk);
        expect_io("R7 first", 1'b1, 8'h18, 1'b0, 2'd0);
        put(1'b0, 8'h11);
        expect_io("R7 bad read", 1'b1, 8'h00, 1'b1, 2'd3);
        put(1'b0, 8'h68);
        expect_io("R7 resume", 1'b1, 8'h04, 1'b0, 2'd0);
        // R8: abort in mid-response
        put(1'b1, 8'h60);
        expect_io("R8 abort code", 1'b1, 8'h00, 1'b1, 2'd2);
        put(1'b0, 8'h00);
        expect_io("R8 step one", 1'b1, 8'h01, 1'b1, 2'd1);
        put(1'b0, 8'h00);
        expect_io("R8 step two", 1'b1, 8'h00, 1'b1, 2'd0);

        // R11: stray data byte in idle, then last-write also aborts
        put(1'b0, 8'h55);
        expect_io("R11 idle data", 1'b1, 8'h00, 1'b1, 2'd3);
        put(1'b1, 8'h62);
        expect_io("R11 last after error", 1'b1, 8'h00, 1'b1, 2'd3);
        put(1'b0, 8'h55);
        expect_io("R11 error data", 1'b1, 8'h00, 1'b1, 2'd3);
        run_req("R11 recover", 8'h18, 8'h01, 2);

        // R9: unknown control code, then last-write aborts
        put(1'b1, 8'h6A);
        expect_io("R9 illegal", 1'b1, 8'h00, 1'b1, 2'd3);
        put(1'b1, 8'h62);
        expect_io("R9 last after illegal", 1'b1, 8'h00, 1'b1, 2'd3);
        run_req("R9 recover", 8'h1C, 8'h01, 2);

        // R10: one data byte too many
        put(1'b1, 8'h61);
        expect_io("R10 begin", 1'b1, 8'h00, 1'b1, 2'd2);
        for (int i = 0; i < DEPTH; i++) begin
            put(1'b0, 8'(i));
            expect_io("R10 fill", 1'b1, 8'h00, 1'b1, 2'd2);
        end
        put(1'b0, 8'hAA);
        expect_io("R10 overflow", 1'b1, 8'h00, 1'b1, 2'd3);
        put(1'b1, 8'h62);
        expect_io("R10 last after overflow", 1'b1, 8'h00, 1'b1, 2'd3);
        // R10: overflow on the final byte
        write_req("R10 final", 8'h18, 8'h01, DEPTH + 1);
        expect_io("R10 final overflow", 1'b1, 8'h00, 1'b1, 2'd3);

        // R8: abort from idle then recovery
        run_req("R8 pre", 8'h18, 8'h04, 2);
        put(1'b1, 8'h60);
        put(1'b0, 8'h00);
        expect_io("R8 idle step one", 1'b1, 8'h01, 1'b1, 2'd1);
        put(1'b0, 8'h00);
        expect_io("R8 idle step two", 1'b1, 8'h00, 1'b1, 2'd0);
        run_req("R8 post", 8'h18, 8'h01, 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule